// File: doc/BRIEF.md
# Program Memory Table Access Unit

This unit moves data between a byte-wide register file and a word-wide program memory. It keeps a word-wide table pointer and a word-wide table latch. The latch has a high byte and a low byte. A table read fetches the whole word at the pointer into the latch and then returns one half of it to the register side. A table write puts one register byte into one half of the latch and then stores the whole latch at the pointer address.

Each request carries four things: a direction, a byte-select flag, a post-advance flag and a write byte. Every table operation lasts two instruction cycles. One instruction cycle is `CLKS_PER_CYC` clocks. The memory access happens at the start of the first cycle. The second cycle does nothing. A `busy` output covers the whole span, and any request or register-load that arrives while `busy` is high is dropped. The pointer and the latch can also be loaded one byte at a time through a small register-load port.

The program memory port is registered. Read data is expected one clock after `pm_re` is asserted.

Top module: `tbl_access_unit`

## Requirements
- R1: A synchronous reset clears the pointer, the latch, `busy`, `pm_we`, `pm_re` and `rd_valid` to zero.
- R2: When `cfg_we` is high while `busy` and `req_valid` are both low, `cfg_wdata` is loaded into one byte. The byte is chosen by `cfg_sel`: 0 is the pointer low byte, 1 is the pointer high byte, 2 is the latch low byte and 3 is the latch high byte. A load that arrives while `busy` or `req_valid` is high has no effect.
- R3: A table read (`req_write`=0) fetches the full word at the pointer into the latch. It asserts `pm_re` for exactly one clock, in the clock after the accepting edge. It then pulses `rd_valid` for one clock, three edges after the accepting edge. In that clock `rd_data` holds the latch low byte when `req_hi`=0 and the latch high byte when `req_hi`=1.
- R4: A table write (`req_write`=1) replaces the selected latch half with `req_wdata` and leaves the other half unchanged. The selected half is the low byte when `req_hi`=0 and the high byte when `req_hi`=1. The write drives the whole new latch on `pm_wdata` with `pm_we` high for exactly one clock, in the clock after the accepting edge.
- R5: With `req_inc`=1 the pointer advances by one as `busy` falls, wrapping from FFFFh to 0000h. With `req_inc`=0 the pointer is unchanged.
- R6: During an operation the memory access uses the pointer value from before the operation. The pointer does not change while `busy` is high.
- R7: After a request is accepted, `busy` is high for exactly 2×`CLKS_PER_CYC` clocks (8 by default). No memory strobe occurs in the second instruction cycle.
- R8: A request that arrives while `busy` is high is ignored. It causes no memory access and changes neither the pointer nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a table operation (taken only when not busy) |
| req_write | input | 1 | 1 = table write, 0 = table read |
| req_hi | input | 1 | Byte select: 1 = high latch byte, 0 = low latch byte |
| req_inc | input | 1 | 1 = advance pointer after the operation |
| req_wdata | input | BYTE_W | Register byte for a table write |
| cfg_we | input | 1 | Direct byte load strobe |
| cfg_sel | input | 2 | Byte chosen for a direct load (see R2) |
| cfg_wdata | input | BYTE_W | Direct load data |
| pm_addr | output | 2*BYTE_W | Program memory word address |
| pm_re | output | 1 | Program memory read strobe |
| pm_rdata | input | 2*BYTE_W | Program memory read word, one clock after `pm_re` |
| pm_we | output | 1 | Program memory write strobe |
| pm_wdata | output | 2*BYTE_W | Program memory write word |
| rd_data | output | BYTE_W | Byte returned by a table read |
| rd_valid | output | 1 | One-clock pulse marking `rd_data` |
| busy | output | 1 | High while a table operation is in progress |
| ptr_out | output | 2*BYTE_W | Current table pointer |
| latch_out | output | 2*BYTE_W | Current table latch |

## Verification
A sequencer count that is off would make `busy` last the wrong number of clocks, or let `rd_valid` or a strobe fall into the second instruction cycle. Either shows on the same operation. A wrong latch half or a lost merge shows on `pm_wdata` one clock after acceptance, or on `rd_data` three edges later. A pointer that advances early shows as a wrong `pm_addr` or as `ptr_out` moving under `busy`. A pointer or latch hit by an ignored request or load shows on `ptr_out` and `latch_out` as soon as that operation ends.

// File: rtl/tbl_pkg.sv
package tbl_pkg;

  typedef enum logic [1:0] {
    SEL_PTR_LO = 2'd0,
    SEL_PTR_HI = 2'd1,
    SEL_LAT_LO = 2'd2,
    SEL_LAT_HI = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic wr;
    logic hi;
    logic inc;
  } tbl_op_t;

endpackage

// File: rtl/tbl_seq.sv
module tbl_seq #(
  parameter int CLKS_PER_CYC = 4
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   start,
  output logic                                   busy,
  output logic [$clog2(2*CLKS_PER_CYC)-1:0]      cnt,
  output logic                                   last
);
  localparam int TOTAL = 2 * CLKS_PER_CYC;
  localparam int CW    = $clog2(TOTAL);
  localparam logic [CW-1:0] LAST = CW'(TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign last = busy && (cnt == LAST);
endmodule

// File: rtl/tbl_ptr.sv
module tbl_ptr #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [BYTE_W-1:0]   ld_byte,
  input  logic                adv,
  output logic [2*BYTE_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= ptr + 1'b1;
    end else begin
      if (ld_lo) ptr[BYTE_W-1:0]        <= ld_byte;
      if (ld_hi) ptr[2*BYTE_W-1:BYTE_W] <= ld_byte;
    end
  end
endmodule

// File: rtl/tbl_latch.sv
module tbl_latch #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [BYTE_W-1:0]   ld_byte,
  input  logic                word_we,
  input  logic [2*BYTE_W-1:0] word_in,
  output logic [2*BYTE_W-1:0] latch
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch <= '0;
    end else if (word_we) begin
      latch <= word_in;
    end else begin
      if (ld_lo) latch[BYTE_W-1:0]        <= ld_byte;
      if (ld_hi) latch[2*BYTE_W-1:BYTE_W] <= ld_byte;
    end
  end
endmodule

// File: rtl/tbl_access_unit.sv
module tbl_access_unit #(
  parameter int BYTE_W       = 8,
  parameter int CLKS_PER_CYC = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_hi,
  input  logic                req_inc,
  input  logic [BYTE_W-1:0]   req_wdata,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_sel,
  input  logic [BYTE_W-1:0]   cfg_wdata,
  output logic [2*BYTE_W-1:0] pm_addr,
  output logic                pm_re,
  input  logic [2*BYTE_W-1:0] pm_rdata,
  output logic                pm_we,
  output logic [2*BYTE_W-1:0] pm_wdata,
  output logic [BYTE_W-1:0]   rd_data,
  output logic                rd_valid,
  output logic                busy,
  output logic [2*BYTE_W-1:0] ptr_out,
  output logic [2*BYTE_W-1:0] latch_out
);
  import tbl_pkg::*;

  localparam int WORD_W = 2 * BYTE_W;
  localparam int CW     = $clog2(2 * CLKS_PER_CYC);
  localparam logic [CW-1:0] PH_LOAD = CW'(1);
  localparam logic [CW-1:0] PH_RET  = CW'(2);

  logic            start, cfg_ok, last;
  logic [CW-1:0]   cnt;
  tbl_op_t         op;
  logic [WORD_W-1:0] ptr, latch, merged;
  logic [BYTE_W-1:0] ld_byte;
  logic            p_lo, p_hi, l_lo, l_hi, word_we;

  assign start  = req_valid && !busy;
  assign cfg_ok = cfg_we && !busy && !req_valid;

  tbl_seq #(.CLKS_PER_CYC(CLKS_PER_CYC)) u_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .cnt(cnt), .last(last)
  );

  // Request and direct loads are mutually exclusive (cfg_ok needs !req_valid)
  assign ld_byte = start ? req_wdata : cfg_wdata;
  assign p_lo    = cfg_ok && (cfg_sel == SEL_PTR_LO);
  assign p_hi    = cfg_ok && (cfg_sel == SEL_PTR_HI);
  assign l_lo    = (cfg_ok && (cfg_sel == SEL_LAT_LO)) || (start && req_write && !req_hi);
  assign l_hi    = (cfg_ok && (cfg_sel == SEL_LAT_HI)) || (start && req_write &&  req_hi);
  assign word_we = busy && !op.wr && (cnt == PH_LOAD);

  tbl_ptr #(.BYTE_W(BYTE_W)) u_ptr (
    .clk(clk), .rst(rst), .ld_lo(p_lo), .ld_hi(p_hi), .ld_byte(ld_byte),
    .adv(last && op.inc), .ptr(ptr)
  );

  tbl_latch #(.BYTE_W(BYTE_W)) u_latch (
    .clk(clk), .rst(rst), .ld_lo(l_lo), .ld_hi(l_hi), .ld_byte(ld_byte),
    .word_we(word_we), .word_in(pm_rdata), .latch(latch)
  );

  // Latch as it will look after the write merge, sent to memory at once
  assign merged = req_hi ? {req_wdata, latch[BYTE_W-1:0]}
                         : {latch[WORD_W-1:BYTE_W], req_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      op       <= '0;
      pm_addr  <= '0;
      pm_re    <= 1'b0;
      pm_we    <= 1'b0;
      pm_wdata <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      pm_re    <= 1'b0;
      pm_we    <= 1'b0;
      rd_valid <= 1'b0;
      if (start) begin
        op       <= '{wr: req_write, hi: req_hi, inc: req_inc};
        pm_addr  <= ptr;
        pm_re    <= !req_write;
        pm_we    <= req_write;
        if (req_write) pm_wdata <= merged;
      end
      if (busy && !op.wr && (cnt == PH_RET)) begin
        rd_data  <= op.hi ? latch[WORD_W-1:BYTE_W] : latch[BYTE_W-1:0];
        rd_valid <= 1'b1;
      end
    end
  end

  assign ptr_out   = ptr;
  assign latch_out = latch;
endmodule

// File: rtl/tbl_access_unit_chk.sv
module tbl_access_unit_chk #(
  parameter int BYTE_W       = 8,
  parameter int CLKS_PER_CYC = 4
) (
  input logic                clk,
  input logic                rst,
  input logic                busy,
  input logic                pm_we,
  input logic                pm_re,
  input logic [2*BYTE_W-1:0] pm_addr,
  input logic                rd_valid,
  input logic [2*BYTE_W-1:0] ptr_out,
  input logic [2*BYTE_W-1:0] latch_out
);
  localparam int TOTAL = 2 * CLKS_PER_CYC;
  localparam int RW    = $clog2(TOTAL) + 2;

  logic [RW-1:0] run;
  always_ff @(posedge clk) begin
    if (rst || !busy) run <= '0;
    else              run <= run + 1'b1;
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!busy && !pm_we && !pm_re && !rd_valid && ptr_out == '0 && latch_out == '0));

  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  assert_re_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    pm_re |=> !pm_re);

  assert_we_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    pm_we |=> !pm_we);

  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> $stable(ptr_out));

  assert_old_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (pm_we || pm_re) |-> (pm_addr == ptr_out));

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run == RW'(TOTAL)));

  assert_busy_bound_R7: assert property (@(posedge clk) disable iff (rst)
    run <= RW'(TOTAL));

  assert_quiet_tail_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && run >= RW'(CLKS_PER_CYC)) |-> !(pm_we || pm_re));
endmodule

bind tbl_access_unit tbl_access_unit_chk #(
  .BYTE_W(BYTE_W), .CLKS_PER_CYC(CLKS_PER_CYC)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .pm_we(pm_we), .pm_re(pm_re),
  .pm_addr(pm_addr), .rd_valid(rd_valid), .ptr_out(ptr_out), .latch_out(latch_out)
);

// File: tb/tbl_access_unit_tb.sv
module tbl_access_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 0, req_write = 0, req_hi = 0, req_inc = 0;
  logic [7:0]  req_wdata = 0;
  logic        cfg_we = 0;
  logic [1:0]  cfg_sel = 0;
  logic [7:0]  cfg_wdata = 0;
  logic [15:0] pm_addr, pm_rdata, pm_wdata, ptr_out, latch_out;
  logic        pm_re, pm_we, rd_valid, busy;
  logic [7:0]  rd_data;

  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tbl_access_unit u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_hi(req_hi), .req_inc(req_inc), .req_wdata(req_wdata),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .pm_addr(pm_addr), .pm_re(pm_re), .pm_rdata(pm_rdata),
    .pm_we(pm_we), .pm_wdata(pm_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .busy(busy), .ptr_out(ptr_out), .latch_out(latch_out)
  );

  function automatic logic [15:0] init_word(int a);
    return {8'(a * 7 + 3), 8'(a ^ 8'hC3)};
  endfunction

  logic [15:0] mem [256];
  logic [15:0] exp_mem [256];
  logic [15:0] q = 0;
  assign pm_rdata = q;

  initial for (int k = 0; k < 256; k++) begin
    mem[k] <= init_word(k);
    exp_mem[k] = init_word(k);
  end

  always @(posedge clk) begin
    if (pm_we) mem[pm_addr[7:0]] <= pm_wdata;
    if (pm_re) q <= mem[pm_addr[7:0]];
  end

  logic [15:0] exp_ptr = 0, exp_latch = 0;

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic cfg_load(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    case (sel)
      2'd0: exp_ptr[7:0]    = d;
      2'd1: exp_ptr[15:8]   = d;
      2'd2: exp_latch[7:0]  = d;
      default: exp_latch[15:8] = d;
    endcase
  endtask

  task automatic set_ptr(input logic [15:0] p);
    cfg_load(2'd0, p[7:0]);
    cfg_load(2'd1, p[15:8]);
  endtask

  // One table operation; disturb adds a same-edge load plus a request and load under busy
  task automatic run_op(input bit w, input bit hi, input bit inc,
                        input logic [7:0] b, input bit disturb);
    int busy_n = 0, re_n = 0, we_n = 0, rv_n = 0, tail_n = 0;
    int re_at = 0, we_at = 0, rv_at = 0;
    logic [15:0] re_addr = 0, we_addr = 0, we_data = 0;
    logic [7:0]  rv_data = 0;
    logic [15:0] old_ptr = exp_ptr;
    @(negedge clk);
    req_valid = 1; req_write = w; req_hi = hi; req_inc = inc; req_wdata = b;
    if (disturb) begin cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = 8'hAA; end
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    for (int n = 1; n <= 8; n++) begin
      if (busy) busy_n++;
      if (pm_re) begin re_n++; re_at = n; re_addr = pm_addr; end
      if (pm_we) begin we_n++; we_at = n; we_addr = pm_addr; we_data = pm_wdata; end
      if (rd_valid) begin rv_n++; rv_at = n; rv_data = rd_data; end
      if (n >= 5 && (pm_re || pm_we)) tail_n++;
      if (disturb && n == 3) begin
        req_valid = 1; req_write = 1; req_hi = 1; req_inc = 1; req_wdata = 8'h77;
      end
      if (disturb && n == 4) begin
        req_valid = 0; cfg_we = 1; cfg_sel = 2'd3; cfg_wdata = 8'h55;
      end
      if (disturb && n == 5) cfg_we = 0;
      @(negedge clk);
    end
    if (w) begin
      if (hi) exp_latch[15:8] = b; else exp_latch[7:0] = b;
      exp_mem[old_ptr[7:0]] = exp_latch;
      chk(we_n, 1, "R4 write strobe count");
      chk(we_at, 1, "R4 write strobe clock");
      chk(we_addr, old_ptr, "R6 write address");
      chk(we_data, exp_latch, "R4 write word");
      chk(re_n, 0, "R4 no read strobe");
    end else begin
      exp_latch = exp_mem[old_ptr[7:0]];
      chk(re_n, 1, "R3 read strobe count");
      chk(re_at, 1, "R3 read strobe clock");
      chk(re_addr, old_ptr, "R6 read address");
      chk(rv_n, 1, "R3 rd_valid count");
      chk(rv_at, 4, "R3 rd_valid clock");
      chk(rv_data, hi ? exp_latch[15:8] : exp_latch[7:0], "R3 rd_data byte");
      chk(we_n, 0, "R3 no write strobe");
    end
    if (inc) exp_ptr = exp_ptr + 16'd1;
    chk(busy_n, 8, "R7 busy length");
    chk(tail_n, 0, "R7 second cycle quiet");
    chk(busy, 0, "R7 busy released");
    chk(ptr_out, exp_ptr, disturb ? "R8 pointer after ignored request" : "R5 pointer");
    chk(latch_out, exp_latch, disturb ? "R8 latch after ignored request" : "R3 R4 latch");
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(busy, 0, "R1 busy");
    chk(ptr_out, 0, "R1 pointer");
    chk(latch_out, 0, "R1 latch");
    chk({pm_we, pm_re, rd_valid}, 0, "R1 strobes");
    rst = 0;
  endtask

  task automatic t_cfg;
    set_ptr(16'h1234);
    cfg_load(2'd2, 8'hCD);
    cfg_load(2'd3, 8'hAB);
    chk(ptr_out, 16'h1234, "R2 pointer load");
    chk(latch_out, 16'hABCD, "R2 latch load");
  endtask

  task automatic t_reads;
    set_ptr(16'h0012);
    run_op(0, 0, 0, 8'h00, 0);
    run_op(0, 1, 1, 8'h00, 0);
    run_op(0, 0, 1, 8'h00, 0);
  endtask

  task automatic t_writes;
    set_ptr(16'h0040);
    run_op(1, 0, 1, 8'h3C, 0);
    run_op(1, 1, 0, 8'hE1, 0);
    set_ptr(16'h0040);
    run_op(0, 1, 1, 8'h00, 0);   // read back R4 store
    run_op(0, 0, 0, 8'h00, 0);
  endtask

  task automatic t_wrap;
    set_ptr(16'hFFFF);
    run_op(0, 1, 1, 8'h00, 0);
    chk(ptr_out, 16'h0000, "R5 wrap to zero");
    run_op(0, 0, 0, 8'h00, 0);
  endtask

  task automatic t_ignore;
    set_ptr(16'h0021);
    run_op(0, 0, 0, 8'h00, 1);
    run_op(1, 0, 0, 8'h99, 1);
    repeat (10) @(negedge clk);
    chk(busy, 0, "R8 no late start");
    chk(ptr_out, exp_ptr, "R2 load ignored");
  endtask

  initial begin
    t_reset();
    t_cfg();
    t_reads();
    t_writes();
    t_wrap();
    t_ignore();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule